// File: doc/BRIEF.md
# ADC Startup Gate and Overflow Flag

This block sits between the decimated output of a four-channel audio converter and whatever consumes its samples. It runs on a fast system clock and watches a frame clock that is synchronous to it. From that frame clock it derives one active edge per frame. The format input selects whether the rising edge or the falling edge is the active one. An active-low power-down input clears every register at once. After release, the block counts 516 active frame edges and only then declares its output valid. Until that point, every sample that passes through is replaced by two's complement zero.

Samples travel as one beat carrying all four signed 24-bit channels. Channel 0 sits in bits 23:0 and channel 3 in bits 95:72. The sample path is a pure valid/ready pass-through with no storage. The consumer's ready drives the producer's ready in the same cycle, so back-pressure reaches the producer with no delay and a beat is never held inside the block. Each accepted beat is also checked for overflow. The result is collected once per frame and delayed by 28 frames, so that the flag lines up with the converter's data latency.

Top module: `adc_startup_gate`

## Requirements
- R1: While `pdn_n` is low, `ready_o` and `ovf_o` are 0 and `m_data_o` is all zero, regardless of the other inputs. Asserting `pdn_n` low clears this state asynchronously.
- R2: A frame edge counts only when the frame clock changes level after at least one clock cycle since power-down release. The level present at release never counts. With `fmt_i2s_i`=0 only low-to-high changes count; with `fmt_i2s_i`=1 only high-to-low changes count.
- R3: `ready_o` rises in the clock cycle after the 516th counted frame edge. It then stays high, with the count saturated, until the next power-down.
- R4: `m_data_o` equals `s_data_i` while `ready_o` is 1, and is all zero while `ready_o` is 0.
- R5: `m_valid_o` follows `s_valid_i` and `s_ready_o` follows `m_ready_i` combinationally. A beat is accepted only when both valid and ready are 1.
- R6: A channel is over range when its signed value is greater than +0x7B5000 or less than -0x7B5000. The code 0x800000 is over range, and exactly +/-0x7B5000 is not.
- R7: The overflow bit of a frame is the OR, over every beat accepted while `ready_o` is 1 since the previous counted edge, of the four channel over-range results. Beats that are refused or arrive during initialization add nothing.
- R8: The overflow bit of the frame closed by counted edge n appears on `ovf_o` from the cycle after edge n+27 until the cycle after edge n+28.
- R9: `ovf_o` is 0 whenever `ready_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| pdn_n | input | 1 | Active-low power-down, asynchronous clear |
| lrck_i | input | 1 | Frame clock, synchronous to clk |
| fmt_i2s_i | input | 1 | 1: falling frame edge is active; 0: rising edge |
| s_valid_i | input | 1 | Input beat valid |
| s_ready_o | output | 1 | Input beat ready (equals m_ready_i) |
| s_data_i | input | 96 | Four signed 24-bit channels, channel 0 in bits 23:0 |
| m_valid_o | output | 1 | Output beat valid (equals s_valid_i) |
| m_ready_i | input | 1 | Output beat ready from consumer |
| m_data_o | output | 96 | Gated samples, same packing as input |
| ready_o | output | 1 | Initialization finished |
| ovf_o | output | 1 | Delayed overflow flag |

## Verification
The assertions cover several properties on every cycle:
- a frame tick never lasts two cycles;
- the frame counter never passes its limit;
- ready never falls without a power-down;
- the overflow flag is never high without ready, and it only rises right after a frame tick.

The bench scenarios cover what needs history to see. These include the exact edge on which ready rises in each edge polarity, the 28-frame alignment of the flag against injected overflow beats, the threshold codes on either side of the limit, beats refused under back-pressure, and the asynchronous clear in the middle of a run.

// File: rtl/adc_gate_pkg.sv
package adc_gate_pkg;
  localparam int unsigned NUM_CH = 4;
  localparam int unsigned CH_W   = 24;
  localparam int unsigned BEAT_W = NUM_CH * CH_W;
  localparam int unsigned INIT_FRAMES = 516;
  localparam int unsigned OVF_DELAY   = 28;
  localparam logic [CH_W-1:0] OVER_LIMIT = 24'h7B5000;

  typedef enum logic {
    EDGE_RISE = 1'b0,
    EDGE_FALL = 1'b1
  } frame_edge_e;
endpackage

// File: rtl/frame_edge_det.sv
module frame_edge_det
  import adc_gate_pkg::*;
(
  input  logic clk,
  input  logic pdn_n,
  input  logic lrck_i,
  input  logic fall_sel_i,
  output logic tick_o
);
  logic lrck_q;
  logic primed_q;
  frame_edge_e sel;

  assign sel = frame_edge_e'(fall_sel_i);

  always_ff @(posedge clk or negedge pdn_n) begin
    if (!pdn_n) begin
      lrck_q   <= 1'b0;
      primed_q <= 1'b0;
    end else begin
      lrck_q   <= lrck_i;
      primed_q <= 1'b1;
    end
  end

  always_comb begin
    tick_o = 1'b0;
    if (primed_q) begin
      unique case (sel)
        EDGE_RISE: tick_o = !lrck_q &&  lrck_i;
        EDGE_FALL: tick_o =  lrck_q && !lrck_i;
        default:   tick_o = 1'b0;
      endcase
    end
  end

  // R2
  single_tick_chk: assert property (@(posedge clk) disable iff (!pdn_n)
    tick_o |=> !tick_o);
endmodule

// File: rtl/init_gate.sv
module init_gate #(
  parameter int unsigned FRAMES = 516
) (
  input  logic clk,
  input  logic pdn_n,
  input  logic tick_i,
  output logic ready_o
);
  localparam int unsigned CW = $clog2(FRAMES + 1);
  localparam logic [CW-1:0] LAST = CW'(FRAMES);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge pdn_n) begin
    if (!pdn_n) begin
      cnt_q <= '0;
    end else if (tick_i && (cnt_q != LAST)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign ready_o = (cnt_q == LAST);

  // R3
  count_bound_chk: assert property (@(posedge clk) disable iff (!pdn_n)
    cnt_q <= LAST);
  // R3
  ready_hold_chk: assert property (@(posedge clk) disable iff (!pdn_n)
    ready_o |=> ready_o);
endmodule

// File: rtl/chan_over.sv
module chan_over #(
  parameter int unsigned W = 24,
  parameter logic [W-1:0] LIMIT = '0
) (
  input  logic [W-1:0] sample_i,
  output logic         over_o
);
  logic          neg;
  logic [W-1:0]  mag;
  logic          most_neg;

  assign neg      = sample_i[W-1];
  assign mag      = neg ? (~sample_i + 1'b1) : sample_i;
  assign most_neg = neg && (sample_i[W-2:0] == '0);
  assign over_o   = most_neg || (mag > LIMIT);
endmodule

// File: rtl/ovf_align.sv
module ovf_align #(
  parameter int unsigned DEPTH = 28
) (
  input  logic clk,
  input  logic pdn_n,
  input  logic tick_i,
  input  logic beat_over_i,
  output logic flag_o
);
  logic             acc_q;
  logic             frame_bit;
  logic [DEPTH-1:0] pipe_q;

  assign frame_bit = acc_q | beat_over_i;

  always_ff @(posedge clk or negedge pdn_n) begin
    if (!pdn_n) begin
      acc_q  <= 1'b0;
      pipe_q <= '0;
    end else if (tick_i) begin
      acc_q  <= 1'b0;
      pipe_q <= {pipe_q[DEPTH-2:0], frame_bit};
    end else begin
      acc_q  <= frame_bit;
    end
  end

  assign flag_o = pipe_q[DEPTH-1];

  // R8
  flag_on_tick_chk: assert property (@(posedge clk) disable iff (!pdn_n)
    $rose(flag_o) |-> $past(tick_i));
  // R8
  flag_hold_chk: assert property (@(posedge clk) disable iff (!pdn_n)
    !tick_i |=> $stable(flag_o));
endmodule

// File: rtl/adc_startup_gate.sv
module adc_startup_gate
  import adc_gate_pkg::*;
(
  input  logic              clk,
  input  logic              pdn_n,
  input  logic              lrck_i,
  input  logic              fmt_i2s_i,
  input  logic              s_valid_i,
  output logic              s_ready_o,
  input  logic [BEAT_W-1:0] s_data_i,
  output logic              m_valid_o,
  input  logic              m_ready_i,
  output logic [BEAT_W-1:0] m_data_o,
  output logic              ready_o,
  output logic              ovf_o
);
  logic              tick;
  logic              done;
  logic [NUM_CH-1:0] ch_over;
  logic              beat_over;

  frame_edge_det u_edge (
    .clk        (clk),
    .pdn_n      (pdn_n),
    .lrck_i     (lrck_i),
    .fall_sel_i (fmt_i2s_i),
    .tick_o     (tick)
  );

  init_gate #(.FRAMES(INIT_FRAMES)) u_init (
    .clk     (clk),
    .pdn_n   (pdn_n),
    .tick_i  (tick),
    .ready_o (done)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    chan_over #(.W(CH_W), .LIMIT(OVER_LIMIT)) u_over (
      .sample_i (s_data_i[c*CH_W +: CH_W]),
      .over_o   (ch_over[c])
    );
  end

  assign s_ready_o = m_ready_i;
  assign m_valid_o = s_valid_i;
  assign m_data_o  = done ? s_data_i : '0;
  assign beat_over = s_valid_i && m_ready_i && done && (|ch_over);

  ovf_align #(.DEPTH(OVF_DELAY)) u_align (
    .clk         (clk),
    .pdn_n       (pdn_n),
    .tick_i      (tick),
    .beat_over_i (beat_over),
    .flag_o      (ovf_o)
  );

  assign ready_o = done;

  // R9
  ovf_needs_ready_chk: assert property (@(posedge clk) disable iff (!pdn_n)
    ovf_o |-> ready_o);
endmodule

// File: tb/test_adc_startup_gate.sv
module test_adc_startup_gate;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic pdn_n, lrck, fmt_i2s, s_valid, s_ready, m_valid, m_ready, ready, ovf;
  logic [95:0] s_data, m_data;

  int n_chk = 0;
  int n_fail = 0;
  int edges;
  bit pend;
  bit hist[4096];

  adc_startup_gate i_adc_startup_gate (
    .clk(clk), .pdn_n(pdn_n), .lrck_i(lrck), .fmt_i2s_i(fmt_i2s),
    .s_valid_i(s_valid), .s_ready_o(s_ready), .s_data_i(s_data),
    .m_valid_o(m_valid), .m_ready_i(m_ready), .m_data_o(m_data),
    .ready_o(ready), .ovf_o(ovf)
  );

  function automatic bit ch_over(logic [23:0] x);
    int v;
    v = int'($signed(x));
    return (v > 8081408) || (v < -8081408);
  endfunction

  function automatic bit any_over(logic [95:0] d);
    bit r = 0;
    for (int c = 0; c < 4; c++) r |= ch_over(d[c*24 +: 24]);
    return r;
  endfunction

  function automatic logic [23:0] pick();
    int r;
    int k;
    r = $urandom % 16;
    k = $urandom % 4194304;
    case (r)
      0: return 24'h7B5000;
      1: return 24'h7B5001;
      2: return 24'h84B000;
      3: return 24'h84AFFF;
      4: return 24'h800000;
      5: return 24'h7FFFFF;
      default: return 24'(k - 2097152);
    endcase
  endfunction

  task automatic chk(bit ok, string req, logic [95:0] a, logic [95:0] e);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, a, e);
    end
  endtask

  task automatic frame(bit act, bit en_beat, logic [95:0] d, bit mr);
    bit exp_ovf;
    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      lrck    = (c < 4) ? ~act : act;
      s_valid = (c == 1) && en_beat;
      s_data  = d;
      m_ready = (c == 1) ? mr : 1'b1;
      if (c == 4) begin
        edges++;
        hist[edges] = pend;
        pend = 0;
      end
      if (c == 1) begin
        #1;
        chk(m_data == ((edges >= 516) ? d : 96'h0), "R4 data gate", m_data,
            (edges >= 516) ? d : 96'h0);
        chk(m_valid == en_beat && s_ready == mr, "R5 handshake",
            {m_valid, s_ready}, {en_beat, mr});
        if (en_beat && mr && edges >= 516 && any_over(d)) pend = 1;
      end
      if (c == 6) begin
        #1;
        exp_ovf = (edges >= 28) ? hist[edges-27] : 1'b0;
        chk(ready == (edges >= 516), act ? "R3 ready rise" : "R2 R3 ready on fall",
            96'(ready), 96'(edges >= 516));
        chk(ovf == exp_ovf, (edges < 516) ? "R9 ovf muted" : "R6 R7 R8 ovf align",
            96'(ovf), 96'(exp_ovf));
      end
    end
  endtask

  task automatic rand_frames(bit act, int n);
    logic [95:0] d;
    for (int i = 0; i < n; i++) begin
      d = {pick(), pick(), pick(), pick()};
      frame(act, ($urandom % 3) != 0, d, ($urandom % 4) != 0);
    end
  endtask

  task automatic start(bit act);
    @(negedge clk);
    pdn_n = 1'b0;
    fmt_i2s = ~act;
    lrck = ~act;
    s_valid = 1'b1;
    m_ready = 1'b1;
    s_data = {4{24'h800000}};
    repeat (3) @(negedge clk);
    #1;
    chk(!ready && !ovf && m_data == 96'h0, "R1 power-down state",
        {ready, ovf, m_data}, 98'h0);
    @(negedge clk);
    pdn_n = 1'b1;
    edges = 0;
    pend = 0;
    for (int i = 0; i < 4096; i++) hist[i] = 1'b0;
    s_valid = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    pdn_n = 1'b0; lrck = 1'b0; fmt_i2s = 1'b0;
    s_valid = 1'b0; m_ready = 1'b1; s_data = '0;

    start(1'b1);
    rand_frames(1'b1, 516);
    // R6 directed threshold codes, one channel at a time
    frame(1'b1, 1'b1, {72'h0, 24'h7B5000}, 1'b1);
    frame(1'b1, 1'b1, {48'h0, 24'h7B5001, 24'h0}, 1'b1);
    frame(1'b1, 1'b1, {24'h0, 24'h84B000, 48'h0}, 1'b1);
    frame(1'b1, 1'b1, {24'h84AFFF, 72'h0}, 1'b1);
    frame(1'b1, 1'b1, {72'h0, 24'h800000}, 1'b1);
    // R7 refused beat adds nothing
    frame(1'b1, 1'b1, {4{24'h800000}}, 1'b0);
    rand_frames(1'b1, 80);

    // R1 asynchronous clear mid-run
    @(negedge clk);
    pdn_n = 1'b0;
    s_data = {4{24'h7FFFFF}};
    #1;
    chk(!ready && !ovf && m_data == 96'h0, "R1 async clear",
        {ready, ovf, m_data}, 98'h0);

    start(1'b0);
    rand_frames(1'b0, 560);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule